// File: doc/BRIEF.md
# Reset-Time Port Option Loader

This block configures the I/O pad options of a small controller from data held in its own program memory instead of from fixed wiring. Once reset is released it walks through the option area, which is the highest 256 bytes of a 64 KB program space. It issues one synchronous read per cycle and captures each returned byte one cycle later. From a few of those bytes it builds the per-pin option vectors: pull-up enable and open-drain output type for port 0, output type for port 1, and pull-up enable for the four interrupt-capable pins of port 7. The two oscillator pins of port 7 carry no options at all.

The processor is kept in reset by the `cpu_run` output. That output rises only when two conditions are both met: every option byte has been fetched, and a settling delay of a set number of tick pulses, counted from reset release, has run out. When `cpu_run` rises the processor begins fetching at address 0000h. Until the load is complete, every option output stays at the safe setting: an input with no pull-up. Reset can be asserted again at any moment; it abandons the work in progress and starts the whole sequence over.

Top module: `option_boot_loader`

## Requirements
- R1: In the first cycle after reset is released, `mem_rd` goes high with `mem_addr` = FF00h. The address then rises by one each cycle up to FFFFh, which is read in cycle 255. From cycle 256 onward `mem_rd` stays low until the next reset.
- R2: `mem_rdata` is taken one cycle after the address was presented. Offsets are counted from FF00h. Offset 0 holds the port 0 output type, one bit per pin, where 1 = open drain. Offset 1 holds the port 0 pull-up: bit 0 covers pins 3..0 and bit 1 covers pins 7..4. Offset 2 holds the port 1 output type, one bit per pin, where 1 = open drain. Bits 3..0 of offset 3 hold the pull-ups of P70..P73. All other bytes and bits have no effect.
- R3: A port 0 pin whose open-drain bit is set never has its pull-up output high, whatever the state of its nibble pull-up bit.
- R4: Before `load_done` is high, all option outputs are 0.
- R5: `load_done` rises in cycle 257, counted with the first released cycle as 0. It stays high until reset.
- R6: `cpu_run` stays low until SETTLE_TICKS pulses of `tick` have been seen since reset release. This holds even when `load_done` is already high.
- R7: `cpu_run` rises in the first cycle in which the load and the settling delay have both finished. When both finish in the same cycle, no extra cycle is added.
- R8: If reset is sampled high at any point, `load_done`, `cpu_run` and all option outputs are 0 in the following cycle. After release, fetching starts again at FF00h.
- R9: While `cpu_run` is high, the option outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| tick | input | 1 | One-cycle pulse that advances the settling delay |
| mem_rd | output | 1 | Read strobe to program memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| p0_pullup | output | 8 | Port 0 pull-up enable per pin |
| p0_opendrain | output | 8 | Port 0 open-drain select per pin |
| p1_opendrain | output | 8 | Port 1 open-drain select per pin |
| p7_pullup | output | 4 | P70..P73 pull-up enable |
| load_done | output | 1 | All option bytes captured |
| cpu_run | output | 1 | Releases the processor to start at 0000h |

## Verification
The loader's last captured byte and the final settling tick can complete in the same cycle. The bench provokes this by placing the last tick so that the delay would end in cycle 257, which is exactly when `load_done` rises. It also covers the neighbouring cases where the delay ends one cycle earlier or one cycle later. In each case `cpu_run` is judged against the later of the two completion cycles, computed independently in the scoreboard. Reset is also applied in the middle of the fetch, during the settling wait, and after release, to confirm that each one aborts cleanly.

// File: rtl/optld_pkg.sv
package optld_pkg;

    localparam int unsigned BYTE_W = 8;

    // Byte offsets inside the option area; the capture logic decodes these.
    localparam int unsigned OFS_P0_TYPE = 0;
    localparam int unsigned OFS_P0_PULL = 1;
    localparam int unsigned OFS_P1_TYPE = 2;
    localparam int unsigned OFS_P7_PULL = 3;

    typedef enum logic [0:0] {
        FS_FETCH = 1'b0,
        FS_IDLE  = 1'b1
    } fetch_state_t;

    typedef struct packed {
        logic [7:0] p0_pu;
        logic [7:0] p0_od;
        logic [7:0] p1_od;
        logic [3:0] p7_pu;
    } pin_opts_t;

    localparam pin_opts_t OPTS_SAFE = '0;

    // Expand a per-nibble pull-up bit into a per-pin mask.
    function automatic logic [3:0] nib_mask(input logic en);
        return en ? 4'hF : 4'h0;
    endfunction

endpackage

// File: rtl/optld_fetch_seq.sv
module optld_fetch_seq
    import optld_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned AREA_BYTES = 256
) (
    input  logic                            clk,
    input  logic                            rst,
    output logic                            mem_rd,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic                            cap_vld,
    output logic [$clog2(AREA_BYTES)-1:0]   cap_off
);
    localparam int unsigned OFF_W = $clog2(AREA_BYTES);
    localparam logic [ADDR_W-1:0] AREA_BASE = ADDR_W'((1 << ADDR_W) - AREA_BYTES);
    localparam logic [OFF_W-1:0]  LAST_OFF  = OFF_W'(AREA_BYTES - 1);

    fetch_state_t     state;
    logic [OFF_W-1:0] off;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FS_FETCH;
            off     <= '0;
            cap_vld <= 1'b0;
            cap_off <= '0;
        end else begin
            cap_vld <= mem_rd;
            cap_off <= off;
            if (state == FS_FETCH) begin
                off <= off + 1'b1;
                if (off == LAST_OFF) state <= FS_IDLE;
            end
        end
    end

    assign mem_rd   = (state == FS_FETCH) && !rst;
    assign mem_addr = AREA_BASE | ADDR_W'(off);

    // R1: consecutive reads walk the area one address at a time
    p_addr_step_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: rtl/optld_capture.sv
module optld_capture
    import optld_pkg::*;
#(
    parameter int unsigned AREA_BYTES = 256
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cap_vld,
    input  logic [$clog2(AREA_BYTES)-1:0]   cap_off,
    input  logic [BYTE_W-1:0]               rdata,
    output logic                            load_done,
    output pin_opts_t                       opts
);
    localparam int unsigned OFF_W = $clog2(AREA_BYTES);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(AREA_BYTES - 1);

    logic [7:0] p0_type_q, p1_type_q;
    logic [1:0] p0_pull_q;
    logic [3:0] p7_pull_q;
    logic [7:0] p0_pu_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            p0_type_q <= '0;
            p1_type_q <= '0;
            p0_pull_q <= '0;
            p7_pull_q <= '0;
            load_done <= 1'b0;
        end else if (cap_vld) begin
            unique case (cap_off)
                OFF_W'(OFS_P0_TYPE): p0_type_q <= rdata;
                OFF_W'(OFS_P0_PULL): p0_pull_q <= rdata[1:0];
                OFF_W'(OFS_P1_TYPE): p1_type_q <= rdata;
                OFF_W'(OFS_P7_PULL): p7_pull_q <= rdata[3:0];
                default: ;
            endcase
            if (cap_off == LAST_OFF) load_done <= 1'b1;
        end
    end

    // Open drain takes priority over the nibble pull-up, pin by pin.
    for (genvar n = 0; n < 2; n++) begin : g_nib
        assign p0_pu_raw[4*n +: 4] = nib_mask(p0_pull_q[n]) & ~p0_type_q[4*n +: 4];
    end

    always_comb begin
        opts = OPTS_SAFE;
        if (load_done) begin
            opts.p0_pu = p0_pu_raw;
            opts.p0_od = p0_type_q;
            opts.p1_od = p1_type_q;
            opts.p7_pu = p7_pull_q;
        end
    end

    // R9: once loaded, no late capture disturbs the options
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (load_done && $past(load_done)) |-> $stable(opts));

endmodule

// File: rtl/optld_settle_timer.sv
module optld_settle_timer #(
    parameter int unsigned SETTLE_TICKS = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(SETTLE_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (tick && !done) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_TICK) done <= 1'b1;
        end
    end

    // R6: the delay only ends on a tick
    p_tick_end_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(tick));

endmodule

// File: rtl/option_boot_loader.sv
module option_boot_loader
    import optld_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned AREA_BYTES   = 256,
    parameter int unsigned SETTLE_TICKS = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        p0_pullup,
    output logic [7:0]        p0_opendrain,
    output logic [7:0]        p1_opendrain,
    output logic [3:0]        p7_pullup,
    output logic              load_done,
    output logic              cpu_run
);
    localparam int unsigned OFF_W = $clog2(AREA_BYTES);

    logic             cap_vld;
    logic [OFF_W-1:0] cap_off;
    logic             settle_done;
    pin_opts_t        opts;

    optld_fetch_seq #(.ADDR_W(ADDR_W), .AREA_BYTES(AREA_BYTES)) u_seq (
        .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .cap_vld(cap_vld), .cap_off(cap_off)
    );

    optld_capture #(.AREA_BYTES(AREA_BYTES)) u_cap (
        .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_off(cap_off),
        .rdata(mem_rdata), .load_done(load_done), .opts(opts)
    );

    optld_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_tmr (
        .clk(clk), .rst(rst), .tick(tick), .done(settle_done)
    );

    assign p0_pullup    = opts.p0_pu;
    assign p0_opendrain = opts.p0_od;
    assign p1_opendrain = opts.p1_od;
    assign p7_pullup    = opts.p7_pu;
    assign cpu_run      = load_done && settle_done;

    // R5: load completes right after the last read has drained
    p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(load_done) |-> (!$past(mem_rd) && $past(mem_rd, 2)));

    // R3: open drain wins over pull-up on port 0
    p_od_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (p0_pullup & p0_opendrain) == 8'h00);

    // R4: safe defaults while loading
    p_safe_r4: assert property (@(posedge clk) disable iff (rst)
        !load_done |-> (p0_pullup == 8'h0 && p0_opendrain == 8'h0 &&
                        p1_opendrain == 8'h0 && p7_pullup == 4'h0));

    // R7: release coincides with one of the two completions
    p_run_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_run) |-> ($rose(load_done) || $rose(settle_done)));

    // R8: reset clears the progress flags
    p_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> (!load_done && !cpu_run));

endmodule

// File: tb/sim_option_boot_loader.sv
module sim_option_boot_loader;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;

    typedef struct {
        logic [7:0] p0_pu;
        logic [7:0] p0_od;
        logic [7:0] p1_od;
        logic [3:0] p7_pu;
        int         run_cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  p0_pullup, p0_opendrain, p1_opendrain;
    logic [3:0]  p7_pullup;
    logic        load_done, cpu_run;

    logic [7:0] mem [0:255];
    int   cyc  = 0;
    int   tper = 4;
    int   tph  = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   run_seen = 1'b0;
    exp_t q[$];
    exp_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    option_boot_loader #(.SETTLE_TICKS(SETTLE)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .p0_pullup(p0_pullup), .p0_opendrain(p0_opendrain),
        .p1_opendrain(p1_opendrain), .p7_pullup(p7_pullup),
        .load_done(load_done), .cpu_run(cpu_run)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (rst) cyc <= 0; else cyc <= cyc + 1;
    end

    assign tick = !rst && ((cyc % tper) == tph);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    function automatic bit opts_zero();
        return p0_pullup == 0 && p0_opendrain == 0 && p1_opendrain == 0 && p7_pullup == 0;
    endfunction

    // Monitor: generic timing checks and scoreboard compare at release.
    always @(negedge clk) begin
        if (rst) begin
            run_seen = 1'b0;
        end else begin
            if (cyc == 0)   chk(mem_rd && mem_addr == 16'hFF00, "R1", mem_addr, 16'hFF00);
            if (cyc == 255) chk(mem_rd && mem_addr == 16'hFFFF, "R1", mem_addr, 16'hFFFF);
            if (cyc == 256) chk(!mem_rd, "R1", mem_rd, 0);
            if (cyc == 200) chk(opts_zero() && !load_done, "R4", {p0_pullup, p7_pullup}, 0);
            if (cyc == 256) chk(!load_done, "R5", load_done, 0);
            if (cyc == 257) chk(load_done, "R5", load_done, 1);
            if (q.size() > 0 && !run_seen) begin
                if (q[0].run_cyc > 257 && cyc == q[0].run_cyc - 1)
                    chk(!cpu_run && load_done, "R6", cpu_run, 0);
                if (cpu_run) begin
                    cur = q.pop_front();
                    run_seen = 1'b1;
                    chk(cyc == cur.run_cyc, "R7", cyc, cur.run_cyc);
                    chk(p0_pullup == cur.p0_pu, "R3", p0_pullup, cur.p0_pu);
                    chk(p0_opendrain == cur.p0_od, "R2", p0_opendrain, cur.p0_od);
                    chk(p1_opendrain == cur.p1_od, "R2", p1_opendrain, cur.p1_od);
                    chk(p7_pullup == cur.p7_pu, "R2", p7_pullup, cur.p7_pu);
                end
            end else if (cpu_run && !run_seen) begin
                run_seen = 1'b1;
                chk(1'b0, "R8", cpu_run, 0);
            end
            if (run_seen && cyc == cur.run_cyc + 20)
                chk(cpu_run && p0_pullup == cur.p0_pu && p0_opendrain == cur.p0_od &&
                    p1_opendrain == cur.p1_od && p7_pullup == cur.p7_pu,
                    "R9", {p0_pullup, p0_opendrain}, {cur.p0_pu, cur.p0_od});
        end
    end

    task automatic load_mem(input logic [7:0] b0, b1, b2, b3, fill);
        for (int i = 0; i < 256; i++) mem[i] = fill;
        mem[0] = b0; mem[1] = b1; mem[2] = b2; mem[3] = b3;
    endtask

    // Driver: program memory and ticks, push the expected release, drop reset.
    task automatic release_case(input logic [7:0] b0, b1, b2, b3, fill,
                                input int per, input int ph, input bit push);
        exp_t e;
        int   sv;
        load_mem(b0, b1, b2, b3, fill);
        tper = per;
        tph  = ph;
        sv = (SETTLE - 1) * per + ph + 1;
        e.p0_pu   = {{4{b1[1]}}, {4{b1[0]}}} & ~b0;
        e.p0_od   = b0;
        e.p1_od   = b2;
        e.p7_pu   = b3[3:0];
        e.run_cyc = (sv > 257) ? sv : 257;
        if (push) q.push_back(e);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic wait_run();
        for (int i = 0; i < 2000 && !run_seen; i++) @(negedge clk);
        if (!run_seen) chk(1'b0, "R7", 0, 1);
        repeat (25) @(negedge clk);
    endtask

    task automatic do_reset(input string req);
        rst = 1'b1;
        @(negedge clk);
        chk(opts_zero() && !load_done && !cpu_run && !mem_rd, req,
            {load_done, cpu_run, p0_pullup}, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(opts_zero() && !load_done && !cpu_run && !mem_rd, "R8", load_done, 0);

        // settle ends early; upper bits of P7 byte and filler bytes ignored (R2)
        release_case(8'h00, 8'h03, 8'h00, 8'hF5, 8'hFF, 4, 0, 1'b1);
        wait_run();
        @(negedge clk) do_reset("R8");

        // settle and load finish in the same cycle; open drain masks pull-ups (R3, R7)
        release_case(8'h0F, 8'h03, 8'hA5, 8'h0A, 8'h00, 36, 4, 1'b1);
        wait_run();
        @(negedge clk) do_reset("R8");

        // settle ends one cycle before load
        release_case(8'h81, 8'h01, 8'h3C, 8'h06, 8'h5A, 36, 3, 1'b1);
        wait_run();
        @(negedge clk) do_reset("R8");

        // settle ends one cycle after load (R7)
        release_case(8'h10, 8'h02, 8'hC3, 8'h09, 8'hA5, 36, 5, 1'b1);
        wait_run();
        @(negedge clk) do_reset("R8");

        // long settle: loaded options valid but CPU still held (R6)
        release_case(8'h81, 8'h01, 8'h3C, 8'h0A, 8'h5A, 100, 0, 1'b1);
        wait_run();
        @(negedge clk) do_reset("R8");

        // abort mid-fetch, then restart with different contents (R8)
        release_case(8'hFF, 8'h03, 8'hFF, 8'h0F, 8'h00, 4, 0, 1'b0);
        while (cyc != 150) @(negedge clk);
        do_reset("R8");
        release_case(8'h5A, 8'h02, 8'h11, 8'h03, 8'h77, 4, 1, 1'b1);
        wait_run();
        @(negedge clk) do_reset("R8");

        // abort during settling wait after load (R8)
        release_case(8'h00, 8'h03, 8'h00, 8'h0F, 8'h00, 100, 0, 1'b0);
        while (cyc != 300) @(negedge clk);
        chk(load_done && !cpu_run && p0_pullup == 8'hFF, "R6", {load_done, cpu_run}, 2'b10);
        do_reset("R8");
        release_case(8'hF0, 8'h03, 8'h0F, 8'h0C, 8'h33, 4, 2, 1'b1);
        wait_run();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog cyc=%0d actual=hung expected=finish", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule